// File: doc/BRIEF.md
# Chip-Erase Sequencer

This block runs a full, security-ordered wipe of the device when software writes a one to the erase command bit. It steps through three engines in turn: volatile memories are cleared first, the main flash array with its emulated-EEPROM region comes next, and the lock row is erased last. Erasing the lock row removes the security protection. Each engine is driven over its own request/acknowledge pair. Only one request is high at a time, and a request is held until its engine acknowledges.

A write made while the register interface is write-protected by the access controller has no effect. So does a write that arrives while a wipe is in progress, and a write with the erase bit at zero. When the last engine acknowledges, a sticky done bit is set. A fuse-reload-pending flag is also set. It stays high until the next reset, because the cleared security state only reaches the fuses after a reset. The memory engines and the fuse logic sit outside the block.

Top module: `wipe_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, all phase requests, busy, done_sts, fuse_reload_pend and flash_region go to zero.
- R2: When idle, a write (ctl_wr=1) with ctl_erase=1 and bus_protected=0 makes busy=1, phase_req=3'b001 and done_sts=0 after the next edge.
- R3: A write with bus_protected=1 is ignored: after the edge, the requests, busy and done_sts are unchanged.
- R4: A write with ctl_erase=0 is ignored.
- R5: At most one bit of phase_req is high. Bit 0 (volatile clear) is always the first request of a wipe.
- R6: An acknowledge on the active phase's bit moves the request to the next bit (0 to 1, 1 to 2) one cycle later. An acknowledge on a non-active bit is ignored.
- R7: flash_region is 3'b011 (bit 0 main array, bit 1 EEPROM-emulation region) while phase_req[1] is high, and 3'b000 otherwise. Bit 2 (auxiliary rows, including the user row) is never set.
- R8: An acknowledge on phase bit 2 (lock row) ends the wipe: one cycle later busy=0, phase_req=0, done_sts=1 and fuse_reload_pend=1.
- R9: done_sts stays high until the next accepted erase write clears it.
- R10: An erase write while busy is ignored and leaves the phase unchanged.
- R11: fuse_reload_pend, once set, stays high through later wipes and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_erase | input | 1 | Value written to the erase command bit |
| bus_protected | input | 1 | Register write protection from the access controller |
| phase_ack | input | 3 | Engine acknowledges: 0 volatile, 1 flash, 2 lock row |
| phase_req | output | 3 | Engine requests, same bit order |
| busy | output | 1 | A wipe is in progress |
| flash_region | output | 3 | Flash erase scope: 0 main, 1 EEPROM emulation, 2 auxiliary |
| done_sts | output | 1 | Sticky completion status |
| fuse_reload_pend | output | 1 | A reset is needed to reload the fuses |

## Verification
Every result is due exactly one clock edge after its cause. An accepted write raises request 0 and busy. An acknowledge moves the request to the next phase. The final acknowledge raises done and the reload flag. flash_region follows the flash request in the same cycle. The bench applies inputs just after a falling edge and compares all outputs at the next falling edge, so exactly one rising edge lies between them. The reference model advances one step per cycle with those same inputs.

// File: rtl/wipe_pkg.sv
// Shared constants for the chip-erase sequencer.
// Assumes the phase order is fixed: volatile, flash, lock row.
package wipe_pkg;
    localparam int unsigned NUM_PHASES = 3;
    localparam int unsigned PH_VOL     = 0;
    localparam int unsigned PH_FLASH   = 1;
    localparam int unsigned PH_LOCK    = 2;
    localparam int unsigned REGION_W   = 3;
    localparam int unsigned RG_MAIN    = 0;
    localparam int unsigned RG_EEP     = 1;
    localparam int unsigned RG_AUX     = 2;
    localparam logic [REGION_W-1:0] FLASH_SCOPE =
        REGION_W'((1 << RG_MAIN) | (1 << RG_EEP));
endpackage

// File: rtl/wipe_cmd_gate.sv
// Decides whether a control write starts a wipe.
// Assumes: one-cycle write strobe. Protected, zero-valued and mid-wipe writes are dropped.
module wipe_cmd_gate (
    input  logic ctl_wr,
    input  logic ctl_erase,
    input  logic bus_protected,
    input  logic seq_busy,
    output logic start
);
    // accept only an unprotected erase write while idle
    always_comb begin
        start = ctl_wr & ctl_erase & ~bus_protected & ~seq_busy;
    end
endmodule

// File: rtl/wipe_phase_chain.sv
// One-hot chain of phase requests. A request holds until its acknowledge,
// then passes to the next bit. The ack on the last bit yields a finish pulse.
// Assumes: start is asserted only when every request is low.
module wipe_phase_chain #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] ack,
    output logic [N-1:0] req,
    output logic         finish
);
    logic [N-1:0] req_nxt;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ph
            if (gi == 0) begin : g_first
                // first phase is entered from start
                always_comb req_nxt[gi] = start | (req[gi] & ~ack[gi]);
            end else begin : g_next
                // later phases are entered from the previous phase's ack
                always_comb req_nxt[gi] = (req[gi-1] & ack[gi-1]) | (req[gi] & ~ack[gi]);
            end
        end
    endgenerate

    // phase request register
    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= req_nxt;
    end

    // completion pulse from the final phase
    always_comb finish = req[N-1] & ack[N-1];
endmodule

// File: rtl/wipe_status.sv
// Sticky completion status and fuse-reload-pending flag.
// Assumes: start and finish are never high in the same cycle.
module wipe_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    output logic done_sts,
    output logic fuse_reload_pend
);
    // done: set at finish, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      done_sts <= 1'b0;
        else if (finish) done_sts <= 1'b1;
        else if (start)  done_sts <= 1'b0;
    end

    // reload flag: set at finish, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)      fuse_reload_pend <= 1'b0;
        else if (finish) fuse_reload_pend <= 1'b1;
    end
endmodule

// File: rtl/wipe_sequencer.sv
// Top of the chip-erase sequencer. Gates the command, runs the phase chain
// (volatile, flash, lock row), publishes the flash scope and the status.
// Assumes: engines hold or pulse their ack while their request is high.
module wipe_sequencer
    import wipe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_wr,
    input  logic                  ctl_erase,
    input  logic                  bus_protected,
    input  logic [NUM_PHASES-1:0] phase_ack,
    output logic [NUM_PHASES-1:0] phase_req,
    output logic                  busy,
    output logic [REGION_W-1:0]   flash_region,
    output logic                  done_sts,
    output logic                  fuse_reload_pend
);
    logic start;
    logic finish;

    wipe_cmd_gate u_gate (
        .ctl_wr       (ctl_wr),
        .ctl_erase    (ctl_erase),
        .bus_protected(bus_protected),
        .seq_busy     (busy),
        .start        (start)
    );

    wipe_phase_chain #(.N(NUM_PHASES)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ack   (phase_ack),
        .req   (phase_req),
        .finish(finish)
    );

    wipe_status u_stat (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .finish          (finish),
        .done_sts        (done_sts),
        .fuse_reload_pend(fuse_reload_pend)
    );

    // busy while any engine is requested
    always_comb busy = |phase_req;

    // flash scope: main array and EEPROM region, never auxiliary rows
    always_comb flash_region = phase_req[PH_FLASH] ? FLASH_SCOPE : '0;
endmodule

// File: rtl/wipe_sequencer_chk.sv
// Assertion checker for wipe_sequencer, attached by bind.
module wipe_sequencer_chk
    import wipe_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctl_wr,
    input logic                  ctl_erase,
    input logic                  bus_protected,
    input logic [NUM_PHASES-1:0] phase_ack,
    input logic [NUM_PHASES-1:0] phase_req,
    input logic                  busy,
    input logic [REGION_W-1:0]   flash_region,
    input logic                  done_sts,
    input logic                  fuse_reload_pend
);
    // R2
    start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && ctl_erase && !bus_protected) |=> (busy && phase_req[PH_VOL] && !done_sts));
    // R3
    prot_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && bus_protected) |=> (!busy && $stable(done_sts)));
    // R5
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(phase_req));
    // R6
    vol_to_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req[PH_VOL] && phase_ack[PH_VOL]) |=> phase_req[PH_FLASH]);
    // R7
    aux_never_chk: assert property (@(posedge clk) disable iff (!rst_n) !flash_region[RG_AUX]);
    // R8
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req[PH_LOCK] && phase_ack[PH_LOCK]) |=> (done_sts && fuse_reload_pend && !busy));
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_sts |=> (done_sts || phase_req[PH_VOL]));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(|(phase_req & phase_ack))) |=> $stable(phase_req));
    // R11
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_reload_pend |=> fuse_reload_pend);
endmodule

bind wipe_sequencer wipe_sequencer_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctl_wr          (ctl_wr),
    .ctl_erase       (ctl_erase),
    .bus_protected   (bus_protected),
    .phase_ack       (phase_ack),
    .phase_req       (phase_req),
    .busy            (busy),
    .flash_region    (flash_region),
    .done_sts        (done_sts),
    .fuse_reload_pend(fuse_reload_pend)
);

// File: tb/wipe_sequencer_bench.sv
// Self-checking bench: directed corner cases, then seeded random stimulus
// compared each cycle against a reference model.
module wipe_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_erase = 1'b0;
    logic       bus_protected = 1'b0;
    logic [2:0] phase_ack = 3'b000;
    logic [2:0] phase_req;
    logic       busy;
    logic [2:0] flash_region;
    logic       done_sts;
    logic       fuse_reload_pend;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [2:0] m_req  = 3'b000;
    logic       m_done = 1'b0;
    logic       m_pend = 1'b0;

    always #10 clk = ~clk;

    wipe_sequencer u_wipe_sequencer (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_erase(ctl_erase),
        .bus_protected(bus_protected), .phase_ack(phase_ack), .phase_req(phase_req),
        .busy(busy), .flash_region(flash_region), .done_sts(done_sts),
        .fuse_reload_pend(fuse_reload_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] req_next(logic [2:0] cur, logic wr, logic er,
                                            logic prot, logic [2:0] ack);
        if (cur == 3'b000) return (wr && er && !prot) ? 3'b001 : 3'b000;
        if ((cur & ack) != 3'b000) return cur << 1;
        return cur;
    endfunction

    function automatic logic [2:0] region_of(logic [2:0] r);
        return r[1] ? 3'b011 : 3'b000;
    endfunction

    // one cycle: drive after a falling edge, step the model, compare at the next falling edge
    task automatic cyc(input logic wr, input logic er, input logic prot, input logic [2:0] ack);
        logic [2:0] nr;
        ctl_wr = wr; ctl_erase = er; bus_protected = prot; phase_ack = ack;
        if (!rst_n) begin
            m_req = 3'b000; m_done = 1'b0; m_pend = 1'b0;
        end else begin
            nr = req_next(m_req, wr, er, prot, ack);
            if (m_req[2] && ack[2]) begin m_done = 1'b1; m_pend = 1'b1; end
            else if (m_req == 3'b000 && nr == 3'b001) m_done = 1'b0;
            m_req = nr;
        end
        @(negedge clk);
        chk("R6 phase_req", 32'(phase_req), 32'(m_req));
        chk("R2 busy", 32'(busy), 32'(|m_req));
        chk("R7 flash_region", 32'(flash_region), 32'(region_of(m_req)));
        chk("R9 done_sts", 32'(done_sts), 32'(m_done));
        chk("R11 fuse_reload_pend", 32'(fuse_reload_pend), 32'(m_pend));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        cyc(0, 0, 0, 3'b000);
        // R1 reset state
        chk("R1 reset req", 32'(phase_req), 32'd0);
        chk("R1 reset status", 32'({busy, done_sts, fuse_reload_pend}), 32'd0);
        rst_n = 1'b1;
        cyc(1, 1, 1, 3'b000);
        // R3 protected write ignored
        chk("R3 protected", 32'(busy), 32'd0);
        cyc(1, 0, 0, 3'b000);
        // R4 zero-valued write ignored
        chk("R4 zero write", 32'(busy), 32'd0);
        cyc(1, 1, 0, 3'b000);
        // R2 accepted start
        chk("R2 start", 32'({busy, phase_req, done_sts}), 32'b1_001_0);
        cyc(0, 0, 0, 3'b110);
        // R5 R6 ack on inactive phases ignored, volatile first
        chk("R5 volatile first", 32'(phase_req), 32'b001);
        cyc(1, 1, 0, 3'b000);
        // R10 write while busy ignored
        chk("R10 busy write", 32'(phase_req), 32'b001);
        cyc(0, 0, 0, 3'b001);
        // R7 flash scope without auxiliary rows
        chk("R7 flash scope", 32'({phase_req, flash_region}), 32'b010_011);
        cyc(0, 0, 0, 3'b010);
        chk("R7 scope off", 32'({phase_req, flash_region}), 32'b100_000);
        cyc(0, 0, 0, 3'b100);
        // R8 completion
        chk("R8 finish", 32'({busy, done_sts, fuse_reload_pend}), 32'b011);
        cyc(0, 0, 0, 3'b111);
        cyc(1, 1, 1, 3'b000);
        // R9 done sticky while idle
        chk("R9 done holds", 32'(done_sts), 32'd1);
        cyc(1, 1, 0, 3'b000);
        // R9 done clears on new start; R11 pending survives it
        chk("R9 done clears", 32'(done_sts), 32'd0);
        chk("R11 pend holds", 32'(fuse_reload_pend), 32'd1);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:26] == 6'd0) rst_n = 1'b0; else rst_n = 1'b1;
            cyc(r[0] & r[1], r[2], r[3] & r[4], {r[5] & r[6], r[7] & r[8], r[9] & r[10]});
        end
        rst_n = 1'b1;
        cyc(1, 1, 0, 3'b000);
        cyc(0, 0, 0, 3'b001);
        cyc(0, 0, 0, 3'b010);
        cyc(0, 0, 0, 3'b100);
        rst_n = 1'b0;
        cyc(0, 0, 0, 3'b000);
        // R11 reset clears pending
        chk("R11 reset clears", 32'(fuse_reload_pend), 32'd0);
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule